// File: doc/BRIEF.md
# Sequential Divider with Condition Flags

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles and returns a quotient, a remainder and three condition flags: negative, zero and overflow. One mode input chooses unsigned or two's-complement operation. A second mode input chooses a word-size result check, which raises overflow when the quotient does not fit in 16 bits. A zero divisor does not start a division. It raises a one-cycle exception pulse, and the previous results stay unchanged.

A request is a single-cycle `start_i` with the operands and mode inputs valid in that cycle. The core takes the magnitudes of both operands and retires one quotient bit per clock with a restoring subtract-and-shift step. On the last step it restores the signs and registers the results and the flags. These values hold until the next successful division.

The controller has two states. `ST_IDLE` waits for a request. Its transition "accept" goes to `ST_RUN` when `start_i` is high and the divisor is nonzero. Its transition "reject" stays in `ST_IDLE` and raises `div0_o` with `done_o` when `start_i` is high and the divisor is zero. `ST_RUN` counts the steps. Its transition "step" stays in `ST_RUN` while the step count is below 31. Its transition "finish" returns to `ST_IDLE` and raises `done_o` on the 32nd step.

Top module: `divider_flags`

## Requirements
- R1: A start with divisor zero raises `div0_o` and `done_o` together for one cycle, in the cycle after the accepting edge. `quot_o`, `rem_o` and all three flags keep their previous values.
- R2: In unsigned mode (`signed_i`=0), `quot_o` is the truncated 32-bit quotient and `rem_o` is the 32-bit remainder.
- R3: In signed mode (`signed_i`=1), the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R4: In unsigned word mode (`word_i`=1, `signed_i`=0), `flag_v_o` is set exactly when the quotient is greater than 0xFFFF.
- R5: In signed word mode, `flag_v_o` is set exactly when the quotient differs from the sign extension of its low 16 bits. With `word_i`=0, `flag_v_o` is always 0.
- R6: `flag_z_o` is set exactly when the 32-bit quotient is zero. `flag_n_o` is set exactly when the quotient is nonzero and its bit 31 is 1, in either mode.
- R7: A signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with no exception.
- R8: For a nonzero divisor, `done_o` is high for exactly one cycle, beginning at the 32nd rising edge after the edge that accepts `start_i`. `done_o` and `div0_o` are low after reset.
- R9: A `start_i` that arrives while a division is running is ignored. It changes neither the pending result nor the number of `done_o` pulses.
- R10: A `start_i` that is high in the same cycle as `done_o` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| signed_i | input | 1 | 1 = two's-complement operands |
| word_i | input | 1 | 1 = check the quotient against 16 bits |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| div0_o | output | 1 | Divide-by-zero pulse |
| done_o | output | 1 | Completion pulse |

## Verification
Two things can happen in the same cycle: the completion of one division and the acceptance of the next request. The bench waits for `done_o` and drives `start_i` in that same cycle, both with a nonzero divisor and with a zero divisor. The scoreboard then expects two separate completions. For each one it checks the edge on which it lands and the values it returns. A zero-divisor request issued in that cycle must report the results just produced as its unchanged values.

// File: rtl/divf_pkg.sv
package divf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } divf_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
    } divf_flags_t;
endpackage

// File: rtl/divf_prep.sv
module divf_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         sgn_i,
    output logic [W-1:0] num_mag_o,
    output logic [W-1:0] den_mag_o,
    output logic         neg_q_o,
    output logic         neg_r_o
);
    logic num_neg, den_neg;

    always_comb begin
        num_neg   = sgn_i & num_i[W-1];
        den_neg   = sgn_i & den_i[W-1];
        num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
        den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
        neg_q_o   = num_neg ^ den_neg;
        neg_r_o   = num_neg;
    end
endmodule

// File: rtl/divf_step.sv
module divf_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] qsh_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] part_o,
    output logic [W-1:0] qsh_o
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {part_i, qsh_i[W-1]};
        trial   = shifted - {1'b0, den_i};
        if (!trial[W]) begin
            part_o = trial[W-1:0];
            qsh_o  = {qsh_i[W-2:0], 1'b1};
        end else begin
            part_o = shifted[W-1:0];
            qsh_o  = {qsh_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/divf_flags.sv
module divf_flags
    import divf_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic [W-1:0] quot_i,
    input  logic         sgn_i,
    input  logic         word_i,
    output divf_flags_t  flags_o
);
    logic [W-1:0] sext_low;
    logic         ovf;

    always_comb begin
        sext_low = {{(W-HW){quot_i[HW-1]}}, quot_i[HW-1:0]};
        if (sgn_i) ovf = (quot_i != sext_low);
        else       ovf = (quot_i[W-1:HW] != '0);
        flags_o.z = (quot_i == '0);
        flags_o.n = (quot_i != '0) && quot_i[W-1];
        flags_o.v = word_i && ovf;
    end
endmodule

// File: rtl/divider_flags.sv
module divider_flags
    import divf_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         signed_i,
    input  logic         word_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         flag_n_o,
    output logic         flag_z_o,
    output logic         flag_v_o,
    output logic         div0_o,
    output logic         done_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    divf_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  part_q, qsh_q, den_q;
    logic          negq_q, negr_q, sgn_q, word_q;

    logic [W-1:0]  num_mag, den_mag;
    logic          neg_q_c, neg_r_c;
    logic [W-1:0]  part_nx, qsh_nx;
    logic [W-1:0]  quot_fin, rem_fin;
    divf_flags_t   flags_fin;
    logic          accept, reject, finish;

    divf_prep #(.W(W)) u_prep (
        .num_i     (dividend_i),
        .den_i     (divisor_i),
        .sgn_i     (signed_i),
        .num_mag_o (num_mag),
        .den_mag_o (den_mag),
        .neg_q_o   (neg_q_c),
        .neg_r_o   (neg_r_c)
    );

    divf_step #(.W(W)) u_step (
        .part_i (part_q),
        .qsh_i  (qsh_q),
        .den_i  (den_q),
        .part_o (part_nx),
        .qsh_o  (qsh_nx)
    );

    always_comb begin
        quot_fin = negq_q ? (~qsh_nx + 1'b1) : qsh_nx;
        rem_fin  = negr_q ? (~part_nx + 1'b1) : part_nx;
    end

    divf_flags #(.W(W), .HW(HW)) u_flags (
        .quot_i  (quot_fin),
        .sgn_i   (sgn_q),
        .word_i  (word_q),
        .flags_o (flags_fin)
    );

    always_comb begin
        accept  = 1'b0;
        reject  = 1'b0;
        finish  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && divisor_i == '0) begin
                    reject = 1'b1;
                end else if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cnt_q == LAST) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            part_q   <= '0;
            qsh_q    <= '0;
            den_q    <= '0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
            sgn_q    <= 1'b0;
            word_q   <= 1'b0;
            quot_o   <= '0;
            rem_o    <= '0;
            flag_n_o <= 1'b0;
            flag_z_o <= 1'b0;
            flag_v_o <= 1'b0;
            div0_o   <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish | reject;
            div0_o <= reject;
            if (accept) begin
                cnt_q  <= '0;
                part_q <= '0;
                qsh_q  <= num_mag;
                den_q  <= den_mag;
                negq_q <= neg_q_c;
                negr_q <= neg_r_c;
                sgn_q  <= signed_i;
                word_q <= word_i;
            end else if (state_q == ST_RUN) begin
                cnt_q  <= cnt_q + 1'b1;
                part_q <= part_nx;
                qsh_q  <= qsh_nx;
            end
            if (finish) begin
                quot_o   <= quot_fin;
                rem_o    <= rem_fin;
                flag_n_o <= flags_fin.n;
                flag_z_o <= flags_fin.z;
                flag_v_o <= flags_fin.v;
            end
        end
    end

    // R1: an exception pulse always comes with the completion pulse
    a_r1_div0_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        div0_o |-> done_o);

    // R1: results are held across a rejected request
    a_r1_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        div0_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(flag_n_o)
                    && $stable(flag_z_o) && $stable(flag_v_o)));

    // R6: negative and zero never appear together
    a_r6_n_z_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(flag_n_o && flag_z_o));

    // R5: overflow stays low outside word mode
    a_r5_v_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div0_o && !word_q) |-> !flag_v_o);

    // R8: no completion before the final step
    a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != LAST) |=> !done_o);

    // R9: a running division is not restarted
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/sim_divider_flags.sv
`timescale 1ns/1ps
module sim_divider_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        signed_i = 1'b0;
    logic        word_i = 1'b0;
    logic [31:0] quot_o, rem_o;
    logic        flag_n_o, flag_z_o, flag_v_o, div0_o, done_o;

    always #2 clk = ~clk;

    divider_flags u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .signed_i(signed_i), .word_i(word_i),
        .quot_o(quot_o), .rem_o(rem_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
        .div0_o(div0_o), .done_o(done_o)
    );

    typedef struct {
        int          edge_n;
        logic [31:0] q;
        logic [31:0] r;
        logic        n, z, v, dz;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] last_q = '0, last_r = '0;
    logic        last_n = 1'b0, last_z = 1'b0, last_v = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic s, input logic w, input string tag);
        exp_t e;
        logic [31:0] q, r;
        e.tag = tag;
        if (b == 0) begin
            e.q = last_q; e.r = last_r;
            e.n = last_n; e.z = last_z; e.v = last_v; e.dz = 1'b1;
            return e;
        end
        if (s) begin
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                q = 32'h8000_0000; r = 0;
            end else begin
                q = $signed(a) / $signed(b);
                r = $signed(a) % $signed(b);
            end
        end else begin
            q = a / b;
            r = a % b;
        end
        e.q = q; e.r = r; e.dz = 1'b0;
        e.z = (q == 0);
        e.n = (q != 0) && q[31];
        if (!w)     e.v = 1'b0;
        else if (s) e.v = (q != {{16{q[15]}}, q[15:0]});
        else        e.v = (q > 32'h0000_FFFF);
        return e;
    endfunction

    // driver: called at a negedge, drives one request and pushes its expectation
    task automatic drive_now(input logic [31:0] a, input logic [31:0] b,
                             input logic s, input logic w, input string tag);
        exp_t e;
        e = model(a, b, s, w, tag);
        e.edge_n = (b == 0) ? cyc + 1 : cyc + 1 + 32;
        if (b != 0) begin
            last_q = e.q; last_r = e.r;
            last_n = e.n; last_z = e.z; last_v = e.v;
        end
        sb.push_back(e);
        dividend_i = a; divisor_i = b; signed_i = s; word_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic w, input string tag);
        @(negedge clk);
        drive_now(a, b, s, w, tag);
        while (sb.size() != 0) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.edge_n, "R8", {e.tag, " done edge"}, cyc, e.edge_n);
                chk(div0_o == e.dz, "R1", {e.tag, " div0"}, div0_o, e.dz);
                chk(quot_o == e.q, e.tag, "quotient", quot_o, e.q);
                chk(rem_o == e.r, e.tag, "remainder", rem_o, e.r);
                chk(flag_n_o == e.n, "R6", {e.tag, " N"}, flag_n_o, e.n);
                chk(flag_z_o == e.z, "R6", {e.tag, " Z"}, flag_z_o, e.z);
                chk(flag_v_o == e.v, "R5", {e.tag, " V"}, flag_v_o, e.v);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (60000) @(posedge clk);
                chk(1'b0, "R8", "watchdog expired", cyc, 0);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0, "R8", "reset done", done_o, 0);
        chk(div0_o == 0, "R8", "reset div0", div0_o, 0);
        chk(quot_o == 0, "R8", "reset quotient", quot_o, 0);

        issue(32'd100, 32'd7, 0, 0, "R2");
        issue(32'hFFFF_FFFF, 32'd1, 0, 0, "R6");
        issue(32'd5, 32'd10, 0, 0, "R6");
        issue(32'h1234_5678, 32'h10, 0, 1, "R4");
        issue(32'd1000, 32'd10, 0, 1, "R4");
        issue(32'h0001_FFFE, 32'd2, 0, 1, "R4");
        issue(-32'sd7, 32'd2, 1, 0, "R3");
        issue(32'd7, -32'sd2, 1, 0, "R3");
        issue(-32'sd7, -32'sd2, 1, 0, "R3");
        issue(32'h0010_0000, 32'd1, 1, 1, "R5");
        issue(32'hFFFF_8000, 32'd1, 1, 1, "R5");
        issue(32'h0000_8000, 32'd1, 1, 1, "R5");
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, "R7");
        issue(32'd77, 32'd0, 0, 0, "R1");
        issue(32'h8000_0000, 32'd0, 1, 1, "R1");

        // R9: start pulses during a running division
        @(negedge clk);
        drive_now(32'd999, 32'd4, 0, 0, "R9");
        repeat (5) @(negedge clk);
        dividend_i = 32'd3; divisor_i = 32'd0; start_i = 1'b1;
        @(negedge clk);
        dividend_i = 32'd50; divisor_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);

        // R10: new request in the completion cycle
        @(negedge clk);
        drive_now(-32'sd100, 32'd9, 1, 0, "R10");
        while (!done_o) @(negedge clk);
        drive_now(32'd1_000_000, 32'd3, 0, 1, "R10");
        while (!done_o) @(negedge clk);
        drive_now(32'd5, 32'd0, 0, 0, "R10");
        while (!done_o) @(negedge clk);
        drive_now(32'd40, 32'd8, 0, 0, "R10");
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule